// File: doc/BRIEF.md
# Guarded Page Table Walker

This block translates a virtual address by walking a tree of page tables in which every entry carries a guard: a bit string of variable length that must match the address bits just below the table index. A matching guard lets one step consume the index bits and the guard bits together, so a chain of tables that would each hold a single valid entry collapses into one fetch. Table sizes may be any power of two and may change between levels, and guard lengths may differ from entry to entry.

A request supplies the virtual address, the physical base of the root table and the root index shift. For each level the walker issues one read of an entry through a simple request/response memory port, checks the guard, strips the consumed bits, and either continues at the next table or ends at a data page, where the untranslated bits form the page offset. It ends with a page fault on a nil entry, a guard mismatch or too many levels. All shift amounts and masks arrive precomputed inside the entries, so a step needs only shifts, one AND, one compare and an add.

Top module: `gpt_walker`

## Requirements
- R1: After reset `done`, `fault`, `pa`, `levels` and `mem_req_valid` are all zero.
- R2: Each level issues exactly one read, with `mem_req_valid` high for one cycle and `mem_req_addr` = table base + (remaining address >> index shift) × ENTRY_BYTES (32 by default); the walker waits any number of cycles for `mem_rsp_valid`, and the number of reads per walk equals `levels`.
- R3: The entry word is laid out from bit 0 upward as: guard (VA_W bits), guard mask (VA_W bits), level shift s1 (SH_W bits), next index shift (SH_W bits), pointer (PA_W bits), leaf bit, valid bit (most significant).
- R4: The guard check passes only when ((remaining >> s1) & mask) equals the guard; a mismatch ends the walk with `fault` = 1.
- R5: An entry with zero mask and zero guard always passes, so the step acts as a plain multi-level lookup.
- R6: After a pass the remaining address becomes remaining & (2^s1 − 1), the next table base is the entry pointer and the next index shift is the entry's next-shift field.
- R7: A passing entry with the leaf bit set ends the walk with `fault` = 0 and `pa` = pointer + stripped remaining address (modulo 2^PA_W).
- R8: An entry with the valid bit clear, including any unmapped location that reads as zero, ends the walk with `fault` = 1.
- R9: A walk that fetches MAX_LEVELS (4 by default) non-leaf entries ends with `fault` = 1 and `levels` = MAX_LEVELS.
- R10: `done` pulses for one cycle per walk; `fault`, `pa` (zero on a fault) and `levels` (entries fetched) change only in that cycle and hold until the next walk ends.
- R11: `start` is ignored while a walk is in progress; only walks started when idle produce a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | VA_W | Virtual address to translate |
| root_base | input | PA_W | Physical base of the root table |
| root_shift | input | SH_W | Index shift for the root table |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | ENT_W | Entry word, layout as in R3 |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Page fault result |
| pa | output | PA_W | Translated physical address |
| levels | output | LVL_W | Number of entries fetched |

## Verification
The assertions assume the memory returns exactly one response per request, at least one cycle after it, and never raises `mem_rsp_valid` while no read is outstanding. The bench's memory model keeps to this by answering each observed request once after a latency of one or more cycles and staying silent otherwise; unmapped addresses read back as an all-zero (nil) entry. The start pulse sent during a busy walk is the only stimulus outside the normal protocol, and it targets the ignore rule rather than the memory contract.

// File: rtl/gpt_pkg.sv
// Shared types for the guarded page table walker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package gpt_pkg;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_state_e;

endpackage

// File: rtl/gpt_entry_unpack.sv
// Splits a raw entry word into its fields.
// Assumes the word layout, from bit 0 upward: guard, guard mask, level
// shift, next index shift, pointer, leaf bit, valid bit.
module gpt_entry_unpack #(
    parameter int VA_W = 48,
    parameter int PA_W = 40,
    parameter int SH_W = 6,
    localparam int O_MASK  = VA_W,
    localparam int O_S1    = 2 * VA_W,
    localparam int O_SNEXT = O_S1 + SH_W,
    localparam int O_PTR   = O_SNEXT + SH_W,
    localparam int O_LEAF  = O_PTR + PA_W,
    localparam int O_VALID = O_LEAF + 1,
    localparam int ENT_W   = O_VALID + 1
) (
    input  logic [ENT_W-1:0] word,
    output logic [VA_W-1:0]  guard,
    output logic [VA_W-1:0]  gmask,
    output logic [SH_W-1:0]  lvl_shift,
    output logic [SH_W-1:0]  next_shift,
    output logic [PA_W-1:0]  ptr,
    output logic             leaf,
    output logic             valid
);

    // Field extraction by fixed offsets
    always_comb begin
        guard      = word[O_MASK-1:0];
        gmask      = word[O_S1-1:O_MASK];
        lvl_shift  = word[O_SNEXT-1:O_S1];
        next_shift = word[O_PTR-1:O_SNEXT];
        ptr        = word[O_LEAF-1:O_PTR];
        leaf       = word[O_LEAF];
        valid      = word[O_VALID];
    end

endmodule

// File: rtl/gpt_entry_addr.sv
// Forms the byte address of the entry selected at the current level.
// Assumes the index shift leaves only the table-size bits of the
// remaining address (upper bits already stripped by earlier steps).
module gpt_entry_addr #(
    parameter int VA_W        = 48,
    parameter int PA_W        = 40,
    parameter int SH_W        = 6,
    parameter int ENTRY_BYTES = 32,
    localparam int ENTRY_LOG2 = $clog2(ENTRY_BYTES)
) (
    input  logic [PA_W-1:0] base,
    input  logic [VA_W-1:0] rem,
    input  logic [SH_W-1:0] idx_shift,
    output logic [PA_W-1:0] addr
);

    logic [VA_W-1:0] idx;

    // Index = top bits of the remaining address, scaled by entry size
    always_comb begin
        idx  = rem >> idx_shift;
        addr = base + (PA_W'(idx) << ENTRY_LOG2);
    end

endmodule

// File: rtl/gpt_step_eval.sv
// Evaluates one translation step: guard compare, bit stripping and the
// leaf physical address.
// Assumes the entry's level shift already accounts for index and guard.
module gpt_step_eval #(
    parameter int VA_W = 48,
    parameter int PA_W = 40,
    parameter int SH_W = 6
) (
    input  logic [VA_W-1:0] rem,
    input  logic [VA_W-1:0] guard,
    input  logic [VA_W-1:0] gmask,
    input  logic [SH_W-1:0] lvl_shift,
    input  logic [PA_W-1:0] ptr,
    output logic            guard_ok,
    output logic [VA_W-1:0] rem_next,
    output logic [PA_W-1:0] leaf_pa
);

    logic [VA_W-1:0] keep_mask;
    logic [VA_W-1:0] probe;

    // Guard compare on the bits just below the index
    always_comb begin
        probe    = (rem >> lvl_shift) & gmask;
        guard_ok = (probe == guard);
    end

    // Strip index and guard bits in one AND; form the leaf address
    always_comb begin
        keep_mask = ~({VA_W{1'b1}} << lvl_shift);
        rem_next  = rem & keep_mask;
        leaf_pa   = ptr + PA_W'(rem_next);
    end

endmodule

// File: rtl/gpt_walker.sv
// Guarded page table walker: one entry read per level, guard check,
// strip, continue or finish with a physical address or a page fault.
// Assumes one memory response per request, at least one cycle later.
module gpt_walker #(
    parameter int VA_W        = 48,
    parameter int PA_W        = 40,
    parameter int SH_W        = 6,
    parameter int ENTRY_BYTES = 32,
    parameter int MAX_LEVELS  = 4,
    localparam int ENT_W      = 2 * VA_W + 2 * SH_W + PA_W + 2,
    localparam int LVL_W      = $clog2(MAX_LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VA_W-1:0]  va,
    input  logic [PA_W-1:0]  root_base,
    input  logic [SH_W-1:0]  root_shift,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  pa,
    output logic [LVL_W-1:0] levels
);
    import gpt_pkg::*;

    walk_state_e      state_q;
    logic [VA_W-1:0]  rem_q;
    logic [PA_W-1:0]  base_q;
    logic [SH_W-1:0]  shift_q;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] lvl_next;
    logic             done_q;
    logic             fault_q;
    logic [PA_W-1:0]  pa_q;
    logic [LVL_W-1:0] levels_q;

    logic [VA_W-1:0]  e_guard;
    logic [VA_W-1:0]  e_gmask;
    logic [SH_W-1:0]  e_s1;
    logic [SH_W-1:0]  e_snext;
    logic [PA_W-1:0]  e_ptr;
    logic             e_leaf;
    logic             e_valid;
    logic             guard_ok;
    logic [VA_W-1:0]  rem_next;
    logic [PA_W-1:0]  leaf_pa;

    gpt_entry_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .SH_W(SH_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) addr_i (
        .base(base_q), .rem(rem_q), .idx_shift(shift_q), .addr(mem_req_addr)
    );

    gpt_entry_unpack #(
        .VA_W(VA_W), .PA_W(PA_W), .SH_W(SH_W)
    ) unpack_i (
        .word(mem_rsp_data), .guard(e_guard), .gmask(e_gmask),
        .lvl_shift(e_s1), .next_shift(e_snext), .ptr(e_ptr),
        .leaf(e_leaf), .valid(e_valid)
    );

    gpt_step_eval #(
        .VA_W(VA_W), .PA_W(PA_W), .SH_W(SH_W)
    ) eval_i (
        .rem(rem_q), .guard(e_guard), .gmask(e_gmask), .lvl_shift(e_s1),
        .ptr(e_ptr), .guard_ok(guard_ok), .rem_next(rem_next),
        .leaf_pa(leaf_pa)
    );

    // Level counter after the entry now being evaluated
    always_comb lvl_next = lvl_q + LVL_W'(1);

    // Walk controller: accept, request, evaluate, continue or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rem_q    <= '0;
            base_q   <= '0;
            shift_q  <= '0;
            lvl_q    <= '0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            pa_q     <= '0;
            levels_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        rem_q   <= va;
                        base_q  <= root_base;
                        shift_q <= root_shift;
                        lvl_q   <= '0;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!e_valid || !guard_ok) begin
                            done_q   <= 1'b1;
                            fault_q  <= 1'b1;
                            pa_q     <= '0;
                            levels_q <= lvl_next;
                            state_q  <= ST_IDLE;
                        end else if (e_leaf) begin
                            done_q   <= 1'b1;
                            fault_q  <= 1'b0;
                            pa_q     <= leaf_pa;
                            levels_q <= lvl_next;
                            state_q  <= ST_IDLE;
                        end else if (lvl_next == LVL_W'(MAX_LEVELS)) begin
                            done_q   <= 1'b1;
                            fault_q  <= 1'b1;
                            pa_q     <= '0;
                            levels_q <= lvl_next;
                            state_q  <= ST_IDLE;
                        end else begin
                            rem_q    <= rem_next;
                            base_q   <= e_ptr;
                            shift_q  <= e_snext;
                            lvl_q    <= lvl_next;
                            state_q  <= ST_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output mapping
    always_comb begin
        mem_req_valid = (state_q == ST_REQ);
        done          = done_q;
        fault         = fault_q;
        pa            = pa_q;
        levels        = levels_q;
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: each entry read request lasts one cycle
    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R10: result outputs move only together with done
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({fault, pa, levels}));

    // R9: a finished walk fetched between one and MAX_LEVELS entries
    a_r9_levels_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (levels != '0 && levels <= LVL_W'(MAX_LEVELS)));

    // R8: a nil entry response ends the walk with a fault next cycle
    a_r8_nil_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid && !e_valid) |=> (done && fault));

    // R11: no request is issued while idle without a start
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> !mem_req_valid);

endmodule

// File: tb/gpt_walker_tb_top.sv
// Scoreboard bench: a driver task computes expected walk results from a
// memory model and queues them; a monitor checks each done pulse.
module gpt_walker_tb_top;

    localparam int  VA_W        = 48;
    localparam int  PA_W        = 40;
    localparam int  SH_W        = 6;
    localparam int  ENTRY_BYTES = 32;
    localparam int  MAX_LEVELS  = 4;
    localparam int  ENT_W       = 2 * VA_W + 2 * SH_W + PA_W + 2;
    localparam int  LVL_W       = $clog2(MAX_LEVELS + 1);
    localparam time CLK_PERIOD  = 10ns;

    typedef struct {
        logic            f;
        logic [PA_W-1:0] p;
        int              lv;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [VA_W-1:0]  va;
    logic [PA_W-1:0]  root_base;
    logic [SH_W-1:0]  root_shift;
    logic             mem_req_valid;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_rsp_valid;
    logic [ENT_W-1:0] mem_rsp_data;
    logic             done;
    logic             fault;
    logic [PA_W-1:0]  pa;
    logic [LVL_W-1:0] levels;

    logic [ENT_W-1:0] mem [logic [PA_W-1:0]];
    exp_t             sb_q[$];
    int               n_checks = 0;
    int               n_fail   = 0;
    int               n_done   = 0;
    int               req_cnt  = 0;
    int               lat      = 1;
    bit               finished = 0;

    gpt_walker #(
        .VA_W(VA_W), .PA_W(PA_W), .SH_W(SH_W),
        .ENTRY_BYTES(ENTRY_BYTES), .MAX_LEVELS(MAX_LEVELS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .va(va),
        .root_base(root_base), .root_shift(root_shift),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .pa(pa), .levels(levels)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // R3: entry word packing, valid bit at the top, guard at bit 0
    function automatic logic [ENT_W-1:0] mk_entry(
        input logic v, input logic lf, input logic [PA_W-1:0] ptr,
        input logic [SH_W-1:0] snext, input logic [SH_W-1:0] s1,
        input logic [VA_W-1:0] gm, input logic [VA_W-1:0] g);
        return {v, lf, ptr, snext, s1, gm, g};
    endfunction

    function automatic logic [ENT_W-1:0] rd(input logic [PA_W-1:0] a);
        if (mem.exists(a)) return mem[a];
        return '0;
    endfunction

    // Reference walk built from R2..R9
    function automatic exp_t model(input logic [VA_W-1:0] v,
                                   input logic [PA_W-1:0] b,
                                   input logic [SH_W-1:0] sh);
        exp_t r;
        logic [VA_W-1:0] rem = v;
        logic [PA_W-1:0] base = b;
        logic [SH_W-1:0] s = sh;
        r.f = 1'b1; r.p = '0; r.lv = MAX_LEVELS;
        for (int i = 0; i < MAX_LEVELS; i++) begin
            logic [ENT_W-1:0] e;
            logic [VA_W-1:0] g, gm, nrem;
            logic [SH_W-1:0] s1, sn;
            logic [PA_W-1:0] ptr;
            e = rd(base + PA_W'((rem >> s) * ENTRY_BYTES));
            {ptr, sn, s1, gm, g} = e[ENT_W-3:0];
            if (!e[ENT_W-1] || (((rem >> s1) & gm) != g)) begin
                r.lv = i + 1;
                return r;
            end
            nrem = rem & ((VA_W'(1) << s1) - VA_W'(1));
            if (e[ENT_W-2]) begin
                r.f = 1'b0; r.p = ptr + PA_W'(nrem); r.lv = i + 1;
                return r;
            end
            base = ptr; s = sn; rem = nrem;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Memory responder: one answer per request after lat cycles (lat >= 1)
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        @(negedge clk);
        forever begin
            if (mem_req_valid) begin
                logic [PA_W-1:0] a;
                a = mem_req_addr;
                req_cnt++;
                repeat (lat) @(negedge clk);
                mem_rsp_data  = rd(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // Monitor: pop and compare on each done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 64'(levels), 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(fault == e.f, "R4/R7/R8/R9", "fault", 64'(fault), 64'(e.f));
                    check(pa == e.p, "R6/R7", "pa", 64'(pa), 64'(e.p));
                    check(int'(levels) == e.lv, "R10", "levels", 64'(levels), 64'(e.lv));
                    check(req_cnt == e.lv, "R2", "reads per walk", 64'(req_cnt), 64'(e.lv));
                end
                req_cnt = 0;
                n_done++;
            end
        end
    end

    // Driver: queue the expected result, pulse start, wait for completion
    task automatic walk(input logic [VA_W-1:0] v, input logic [PA_W-1:0] b,
                        input logic [SH_W-1:0] sh, input int l);
        int target;
        lat = l;
        sb_q.push_back(model(v, b, sh));
        target = n_done + 1;
        @(negedge clk);
        va = v; root_base = b; root_shift = sh; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (n_done == target);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t x;
        logic [PA_W-1:0] hold_pa;
        logic            hold_f;
        logic [LVL_W-1:0] hold_lv;
        rst_n = 1'b0; start = 1'b0; va = '0; root_base = '0; root_shift = '0;

        // Tables: guarded three-field walk under root 0x1000 (4-bit index)
        mem[40'h1000 + 40'hA * 32] = mk_entry(1, 0, 40'h20000, 6'd30, 6'd36, 48'hFF, 48'h5C);
        mem[40'h20000 + 40'h2D * 32] = mk_entry(1, 1, 40'h3000000, 6'd0, 6'd24, 48'h3F, 48'h15);
        // Large leaf directly in the root
        mem[40'h1000 + 40'h3 * 32] = mk_entry(1, 1, 40'h10_0000_0000, 6'd0, 6'd40, 48'hF, 48'h9);
        // Conventional two-level tables (zero guards), 8-bit indices
        mem[40'h8000 + 40'h7E * 32] = mk_entry(1, 0, 40'h9000, 6'd32, 6'd40, 48'h0, 48'h0);
        mem[40'h9000 + 40'hC4 * 32] = mk_entry(1, 1, 40'h01_0000_0000, 6'd0, 6'd32, 48'h0, 48'h0);
        // Self-referencing non-leaf chain for the depth limit
        mem[40'h40000] = mk_entry(1, 0, 40'h40000, 6'd10, 6'd10, 48'h0, 48'h0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1", "done", 64'(done), 64'd0);
        check(fault == 1'b0, "R1", "fault", 64'(fault), 64'd0);
        check(pa == '0, "R1", "pa", 64'(pa), 64'd0);
        check(levels == '0, "R1", "levels", 64'(levels), 64'd0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R4 R6 R7: guarded two-step walk; also hand-derived address
        x = model({4'hA, 8'h5C, 6'h2D, 6'h15, 24'h123456}, 40'h1000, 6'd44);
        check(x.p == 40'h3123456 && !x.f, "R7", "model sanity", 64'(x.p), 64'h3123456);
        walk({4'hA, 8'h5C, 6'h2D, 6'h15, 24'h123456}, 40'h1000, 6'd44, 1);
        // R10: results hold after the pulse
        hold_pa = pa; hold_f = fault; hold_lv = levels;
        repeat (4) @(negedge clk);
        check(pa == hold_pa && fault == hold_f && levels == hold_lv, "R10",
              "hold", 64'(pa), 64'(hold_pa));
        check(done == 1'b0, "R10", "done pulse width", 64'(done), 64'd0);

        // R4: guard mismatch at the second level, long latency (R2)
        walk({4'hA, 8'h5C, 6'h2D, 6'h16, 24'h123456}, 40'h1000, 6'd44, 5);
        // R4: guard mismatch at the first level
        walk({4'hA, 8'h5D, 6'h2D, 6'h15, 24'h000001}, 40'h1000, 6'd44, 2);
        // R5: zero-guard conventional lookup
        walk({8'h7E, 8'hC4, 32'hDEAD_BEEF}, 40'h8000, 6'd40, 3);
        // R7: leaf at the root level
        walk({4'h3, 4'h9, 40'hAB_CDEF_0123}, 40'h1000, 6'd44, 1);
        // R8: unmapped root slot reads as a nil entry
        walk({4'hB, 44'h0}, 40'h1000, 6'd44, 2);
        // R9: depth limit on a self-referencing chain
        walk({4'h0, 34'h0, 10'h155}, 40'h40000, 6'd44, 1);

        // R11: start during a walk is ignored
        lat = 6;
        sb_q.push_back(model({4'h3, 4'h9, 40'h00_0000_0042}, 40'h1000, 6'd44));
        @(negedge clk);
        va = {4'h3, 4'h9, 40'h00_0000_0042}; root_base = 40'h1000;
        root_shift = 6'd44; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        va = {4'hB, 44'h0}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(n_done == 8, "R11", "walks completed", 64'(n_done), 64'd8);
        check(pa == 40'h10_0000_0042 && !fault, "R11", "first walk result",
              64'(pa), 64'h10_0000_0042);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule